// File: doc/BRIEF.md
# I2C Target Controller with Sticky Status Flags

This block is the target (slave) side of a two-wire serial bus. It synchronizes the raw SCL and SDA pins, finds start and stop conditions, and shifts in an address byte to compare with a programmable 7-bit own address. When the address matches, the block acknowledges it. It then takes in data bytes from the master or sends bytes to it, depending on the read/write bit that ended the address byte. Receive bytes appear on a parallel output. Transmit bytes are taken from a parallel input at the start of each byte.

A byte-wide status word holds sticky event flags: bus busy, address matched, transmit direction, transmit error and the last acknowledge bit seen. Software clears any flag by writing 1 to its bit. Lowering the enable clears all of them, and a stop condition clears them on its own. While it sends a byte, the block compares each bit it puts out with the level it reads back from the bus. On a mismatch it flags an error and stops driving SDA until that byte is over. A one-cycle interrupt pulse follows every acknowledge bit, so that software can service the data ports.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, status is 0x00, sda_oe is 0 and irq is 0.
- R2: Status bit 0 (busy) is set by a start condition (SDA falling while SCL is high).
- R3: Status bit 3 (matched) is set when the upper seven bits of the address byte equal own_addr.
- R4: When the address matches, status bit 4 (direction) takes the received read/write bit: 1 means the block transmits, 0 means it receives. A repeated start with a write address therefore clears it.
- R5: If, while transmitting, the sampled SDA differs from the bit being sent, status bit 2 (transmit error) is set and SDA stays released for the rest of that byte. The next byte is driven normally.
- R6: Status bit 1 takes the SDA level sampled on the ninth clock of the address phase and of every data byte (1 = NACK).
- R7: A status write clears each bit whose write-data bit is 1. Bits written 0 are unchanged. Bits 7:5 always read 0.
- R8: While en is 0, status is held at 0x00, the bus is ignored and SDA is never driven.
- R9: The block pulls SDA low on the ninth clock after a matching address and after each received data byte. After a non-matching address it stays off the bus until the next start.
- R10: A received data byte, MSB first, appears on rx_data once its eighth bit has been sampled on the SCL rising edge.
- R11: Transmit bytes are taken from tx_data when the byte begins and sent MSB first. SDA changes only while SCL is low. A master ACK (0) leads to another byte; a NACK (1) ends the transfer.
- R12: irq is high for exactly one clock after every acknowledge bit of an addressed transfer, and at no other time.
- R13: A repeated start begins a new address reception whatever byte was in progress.
- R14: A stop condition (SDA rising while SCL is high) clears all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Unit enable; 0 clears flags and idles the engine |
| own_addr | input | 7 | Programmed own address |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| tx_data | input | 8 | Next byte to transmit |
| rx_data | output | 8 | Last byte received |
| stat_wr | input | 1 | Status write strobe (write-1-to-clear) |
| stat_wdata | input | 8 | Status write data |
| status | output | 8 | Flags: bit4 direction, bit3 matched, bit2 tx error, bit1 ack, bit0 busy |
| irq | output | 1 | One-cycle pulse after each acknowledge bit |

## Verification
Random transfers use random own addresses, random data and 1 to 3 bytes, in both directions. A quarter of the addresses are deliberately wrong, which separates the acknowledge path from the stay-off-the-bus path and shows whether interrupts are counted only for addressed transfers. Directed cases then cover the rest. A master that forces SDA low on a released bit tells a real error release apart from a block that keeps driving. A repeated start in both directions checks that the direction flag is re-derived. Writes of zero and of unused bits separate write-1-to-clear from a plain store. A transfer made while disabled proves that the bus is ignored.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  localparam int unsigned FLG_BUSY  = 0;
  localparam int unsigned FLG_ACK   = 1;
  localparam int unsigned FLG_TERR  = 2;
  localparam int unsigned FLG_MATCH = 3;
  localparam int unsigned FLG_DIR   = 4;
  localparam logic [BYTE_W-1:0] FLG_MASK = 8'h1F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_RX, ST_ACK_R, ST_TX, ST_MACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw, cur, prv;
  assign raw = {scl_raw, sda_raw};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '1;
      else     sr <= {sr[STAGES-1:0], raw[g]};
    end
    assign cur[g] = sr[STAGES-1];
    assign prv[g] = sr[STAGES];
  end

  assign sda_s     = cur[0];
  assign scl_rise  = cur[1] & ~prv[1];
  assign scl_fall  = ~cur[1] & prv[1];
  assign start_det = cur[1] & prv[1] & prv[0] & ~cur[0];
  assign stop_det  = cur[1] & prv[1] & ~prv[0] & cur[0];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [BYTE_W-1:0] rx_data,
  output logic              drive_low,
  output logic              ev_match,
  output logic              ev_ack,
  output logic              ev_err
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  tgt_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              drv, blk, rw_q, mack_q, live;
  logic [BYTE_W-1:0] in_byte;

  assign in_byte = {sh[BYTE_W-2:0], sda_s};
  assign live    = en & ~start_det & ~stop_det;

  assign ev_match = live & (st == ST_ADDR) & scl_rise & (cnt == LAST)
                  & (in_byte[BYTE_W-1:1] == own_addr);
  assign ev_ack   = live & scl_rise &
                    ((((st == ST_ACK_A) | (st == ST_ACK_R)) & drv) | (st == ST_MACK));
  assign ev_err   = live & (st == ST_TX) & scl_rise & ~blk & (sda_s != sh[BYTE_W-1]);

  assign drive_low = (((st == ST_ACK_A) | (st == ST_ACK_R)) & drv)
                   | ((st == ST_TX) & ~blk & ~sh[BYTE_W-1]);

  always_ff @(posedge clk) begin
    if (rst) rx_data <= '0;
    else if (en && st == ST_RX && scl_rise && cnt == LAST && !start_det && !stop_det)
      rx_data <= in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; drv <= 1'b0; blk <= 1'b0;
      rw_q <= 1'b0; mack_q <= 1'b0;
    end else if (start_det) begin
      st <= ST_ADDR; cnt <= '0; drv <= 1'b0; blk <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; drv <= 1'b0; blk <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: if (scl_rise) begin
          sh  <= in_byte;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            rw_q <= sda_s;
            st   <= ev_match ? ST_ACK_A : ST_IDLE;
          end
        end
        ST_ACK_A, ST_ACK_R: if (scl_fall) begin
          if (!drv) drv <= 1'b1;
          else begin
            drv <= 1'b0;
            cnt <= '0;
            if (st == ST_ACK_A && rw_q) begin
              st <= ST_TX; sh <= tx_data;
            end else st <= ST_RX;
          end
        end
        ST_RX: if (scl_rise) begin
          sh  <= in_byte;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= ST_ACK_R;
        end
        ST_TX: begin
          if (ev_err) blk <= 1'b1;
          if (scl_fall) begin
            sh  <= sh << 1;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              st <= ST_MACK; blk <= 1'b0;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_q <= sda_s;
          if (scl_fall) begin
            if (!mack_q) begin
              st <= ST_TX; sh <= tx_data; cnt <= '0;
            end else st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              ev_match,
  input  logic              ev_rw,
  input  logic              ev_ack,
  input  logic              ev_ackval,
  input  logic              ev_err,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] flags
);
  logic [BYTE_W-1:0] nxt;

  always_comb begin
    nxt = flags & ~(wr ? wdata : '0);
    if (start_det) nxt[FLG_BUSY] = 1'b1;
    if (ev_match) begin
      nxt[FLG_MATCH] = 1'b1;
      nxt[FLG_DIR]   = ev_rw;
    end
    if (ev_err) nxt[FLG_TERR] = 1'b1;
    if (ev_ack) nxt[FLG_ACK]  = ev_ackval;
    nxt = nxt & FLG_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || stop_det) flags <= '0;
    else                        flags <= nxt;
  end
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              stat_wr,
  input  logic [BYTE_W-1:0] stat_wdata,
  output logic [BYTE_W-1:0] status,
  output logic              irq
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic drive_low, ev_match, ev_ack, ev_err;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine u_eng (
    .clk(clk), .rst(rst), .en(en), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .tx_data(tx_data), .rx_data(rx_data),
    .drive_low(drive_low), .ev_match(ev_match), .ev_ack(ev_ack), .ev_err(ev_err)
  );

  i2c_tgt_flags u_flags (
    .clk(clk), .rst(rst), .en(en),
    .start_det(start_det), .stop_det(stop_det),
    .ev_match(ev_match), .ev_rw(sda_s), .ev_ack(ev_ack), .ev_ackval(sda_s),
    .ev_err(ev_err), .wr(stat_wr), .wdata(stat_wdata), .flags(status)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sda_oe <= 1'b0;
      irq    <= 1'b0;
    end else begin
      sda_oe <= drive_low;
      irq    <= ev_ack;
    end
  end
endmodule

// File: rtl/i2c_target_ctrl_chk.sv
module i2c_target_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       stat_wr,
  input logic [7:0] status,
  input logic       sda_oe,
  input logic       irq
);
  assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_unused_bits_R7: assert property (@(posedge clk) disable iff (rst)
    status[7:5] == 3'b000);

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (status == 8'h00));

  assert_disable_releases_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> !sda_oe);

  assert_busy_drop_clears_R14: assert property (@(posedge clk) disable iff (rst)
    ($fell(status[0]) && !$past(stat_wr)) |-> (status == 8'h00));

  assert_dir_with_match_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(status[4]) |-> status[3]);
endmodule

bind i2c_target_ctrl i2c_target_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .stat_wr(stat_wr),
  .status(status), .sda_oe(sda_oe), .irq(irq)
);

// File: tb/i2c_target_ctrl_tb.sv
module i2c_target_ctrl_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, en = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, irq, stat_wr = 1'b0;
  logic [7:0] tx_data = 8'h00, rx_data, stat_wdata = 8'h00, status;
  logic       sda_line;
  int         errs = 0, checks = 0, irq_cnt = 0;

  assign sda_line = sda_m & ~sda_oe;

  i2c_target_ctrl u_dut (
    .clk(clk), .rst(rst), .en(en), .own_addr(own_addr),
    .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .tx_data(tx_data), .rx_data(rx_data),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .status(status), .irq(irq)
  );

  always @(posedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

  function automatic logic [7:0] exp_stat(input bit m, input bit rw, input bit ak);
    return {3'b000, m & rw, m, 1'b0, ak, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic mstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic mbit(input bit v, output bit r);
    sda_m = v; tick(Q); scl_m = 1'b1; tick(Q);
    r = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic mbyte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) mbit(b[i], r);
    mbit(1'b1, ack);
  endtask

  task automatic mread(input logic [7:0] force_low, input bit mack,
                       input logic [7:0] next_tx, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      mbit(~force_low[i], r);
      d[i] = r;
    end
    tx_data = next_tx;
    mbit(mack, r);
  endtask

  task automatic swrite(input logic [7:0] w);
    stat_wdata = w; stat_wr = 1'b1; tick(1); stat_wr = 1'b0; tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired before the run ended");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int base;
    void'($urandom(32'd2024));
    tick(4); rst = 1'b0; tick(2);
    chk("R1 status after reset", status, 8'h00);
    chk("R1 sda_oe after reset", sda_oe, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);

    // directed write transfer
    base = irq_cnt;
    mstart();
    chk("R2 busy after start", status, 8'h01);
    mbyte({7'h2A, 1'b0}, ack);
    chk("R9 address ACK driven", ack, 1'b0);
    chk("R3 R6 status after write address", status, exp_stat(1, 0, 0));
    mbyte(8'hA5, ack);
    chk("R9 data ACK driven", ack, 1'b0);
    chk("R10 rx_data", rx_data, 8'hA5);
    // R13 repeated start, now a read: direction set
    tx_data = 8'h3C;
    mstart();
    mbyte({7'h2A, 1'b1}, ack);
    chk("R13 R4 status after repeated start read", status, exp_stat(1, 1, 0));
    mread(8'h00, 1'b1, 8'h00, d);
    chk("R11 transmitted byte", d, 8'h3C);
    chk("R6 master NACK captured", status, exp_stat(1, 1, 1));
    chk("R12 irq count per ack bit", irq_cnt - base, 4);
    // R7 write-1-to-clear
    swrite(8'h00);
    chk("R7 writing zero keeps flags", status, 8'h1B);
    swrite(8'hE2);
    chk("R7 clear ack bit only", status, 8'h19);
    // R4 repeated start with write address clears direction
    mstart();
    mbyte({7'h2A, 1'b0}, ack);
    chk("R4 direction cleared by write address", status, exp_stat(1, 0, 0));
    mstop(); tick(2);
    chk("R14 stop clears all flags", status, 8'h00);

    // R5 transmit error: master forces the first (released) bit low
    tx_data = 8'hF0;
    mstart();
    mbyte({7'h2A, 1'b1}, ack);
    mread(8'h80, 1'b0, 8'h00, d);
    chk("R5 SDA released after mismatch", d, 8'h7F);
    chk("R5 error flag set", status, 8'h1D);
    mread(8'h00, 1'b1, 8'h00, d);
    chk("R5 next byte driven again", d, 8'h00);
    chk("R5 R6 flags after second byte", status, 8'h1F);
    // R8 disable clears and ignores the bus
    en = 1'b0; tick(2);
    chk("R8 disable clears flags", status, 8'h00);
    mstop();
    base = irq_cnt;
    mstart();
    mbyte({7'h2A, 1'b0}, ack);
    chk("R8 no ACK while disabled", ack, 1'b1);
    chk("R8 flags stay clear while disabled", status, 8'h00);
    chk("R8 no irq while disabled", irq_cnt - base, 0);
    mstop(); en = 1'b1; tick(2);

    // random transfers
    for (int t = 0; t < 24; t++) begin
      logic [6:0] oa, ta;
      logic [7:0] v [4];
      bit hit, rw, lastack;
      int n;
      oa = 7'($urandom);
      hit = ($urandom % 4) != 0;
      ta = hit ? oa : (oa ^ (7'($urandom % 127) + 7'd1));
      rw = 1'($urandom);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < 4; k++) v[k] = 8'($urandom);
      own_addr = oa;
      tx_data = v[0];
      base = irq_cnt;
      lastack = 1'b0;
      mstart();
      mbyte({ta, rw}, ack);
      chk("R9 R3 random address ack", ack, !hit);
      chk("R3 R4 random status after address", status, hit ? exp_stat(1, rw, 0) : 8'h01);
      if (!hit) begin
        mbyte(v[0], ack);
        chk("R9 off bus after mismatch", ack, 1'b1);
        chk("R12 no irq when not addressed", irq_cnt - base, 0);
      end else if (!rw) begin
        for (int k = 0; k < n; k++) begin
          mbyte(v[k], ack);
          chk("R9 random data ACK", ack, 1'b0);
          chk("R10 random rx_data", rx_data, v[k]);
        end
        chk("R12 random irq count", irq_cnt - base, n + 1);
      end else begin
        for (int k = 0; k < n; k++) begin
          mread(8'h00, k == n - 1, v[k+1], d);
          chk("R11 random transmitted byte", d, v[k]);
        end
        lastack = 1'b1;
        chk("R12 random irq count", irq_cnt - base, n + 1);
      end
      if (hit) chk("R6 random final status", status, exp_stat(1, rw, lastack));
      mstop(); tick(2);
      chk("R14 random stop clears", status, 8'h00);
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule